// File: doc/BRIEF.md
# Multi-Mode DMA Channel Controller

This block sequences direct memory transfers for seven peripheral channels. Software programs each channel through an I/O-mapped register window. It writes a 16-bit start address, a transfer count, a timing mode and two page bytes. When a peripheral raises its request line, the controller picks a channel and acknowledges it. It then drives a 32-bit transfer address and holds a bus strobe for the number of bus clocks that the channel's timing mode calls for. Four modes are offered: a compatible timing of 8 clocks, type A of 6 clocks, type B of 4 clocks and a burst type C of 1 clock per transfer.

The address is built from three parts. The channel's running 16-bit address gives bits 15:0, the low page byte gives bits 23:16 and the high page byte gives bits 31:24. After every transfer the running address steps up by one and the running count steps down by one. The transfer made while the count reads zero raises terminal count. After that the channel stops. Pending channels are served in rotating order, so a channel that keeps its request high cannot shut out the others.

A single state machine with two states drives the transfers. IDLE moves to XFER when an eligible request is present. XFER stays in XFER while strobe cycles remain. On its last cycle XFER either reloads for the next winner, with no gap, or returns to IDLE when nothing is eligible.

Top module: `dma_multimode_ctrl`

## Requirements
- R1: After reset, bus_strobe, bus_tc and dack are all low, and every register field reads back as zero.
- R2: Register window: io_addr[5:3] selects channel 0 to 6 and io_addr[2:0] selects the field. The fields are 0 start address (16 bits), 1 count (16 bits), 2 mode (bits 1:0), 3 low page (bits 7:0), 4 high page (bits 7:0), 5 running address (read only) and 6 running count (read only). Writing field 0 also loads the running address. Writing field 1 also loads the running count. Channel code 7 reads zero and ignores writes.
- R3: While bus_strobe is high, bus_addr equals {high page, low page, running address} of the served channel.
- R4: The mode field sets the strobe length of one transfer: 0 gives 8 clocks, 1 gives 6, 2 gives 4 and 3 gives 1.
- R5: dack is one-hot for the served channel exactly while bus_strobe is high, and zero otherwise.
- R6: After each transfer the running address increases by one. It wraps within 16 bits and leaves both page bytes unchanged.
- R7: After each transfer the running count decreases by one. bus_tc is high in the last strobe cycle of the transfer made while the count reads 0, and the count then reads 16'hFFFF. A count of K therefore yields K+1 transfers.
- R8: After terminal count a channel ignores its request until its count field is written again.
- R9: Rotating priority: after serving channel k, the search for the next winner starts at k+1 and wraps past 6 to 0. After reset the search starts at channel 0.
- R10: A request seen while idle starts a transfer on the next clock. A request still eligible at the last cycle of a transfer starts the next transfer on the next clock, with no idle cycle between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | Register write strobe |
| io_addr | input | 6 | Register select: channel in bits 5:3, field in bits 2:0 |
| io_wdata | input | 16 | Register write data |
| io_rdata | output | 16 | Register read data, combinational from io_addr |
| dreq | input | 7 | Per-channel transfer requests |
| dack | output | 7 | Per-channel acknowledges |
| bus_addr | output | 32 | Transfer address |
| bus_strobe | output | 1 | High for every bus clock of a transfer |
| bus_tc | output | 1 | Terminal count, in the final strobe cycle |

## Verification
The hardest situation to reach is the rotation across several requesters that are all pending at once. It has to include the wrap from channel 6 back to channel 0, and the exclusion of a channel in the same cycle in which it reaches terminal count. The stimulus resets the block so the pointer starts at 0. It then arms three channels in burst mode with three transfers each and raises all three requests in one cycle. The acknowledge order is checked on every clock, and so is the absence of a gap. A follow-up pair on channels 6 and 0 shows the wrap of the pointer. Separate scenarios hold a request high past terminal count and then re-arm the channel with a count write.

// File: rtl/dma_mm_pkg.sv
package dma_mm_pkg;

    typedef enum logic [1:0] {
        TM_COMPAT = 2'd0,
        TM_A      = 2'd1,
        TM_B      = 2'd2,
        TM_C      = 2'd3
    } tmode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } state_e;

    localparam logic [2:0] FLD_BASE = 3'd0;
    localparam logic [2:0] FLD_CNT  = 3'd1;
    localparam logic [2:0] FLD_MODE = 3'd2;
    localparam logic [2:0] FLD_LOPG = 3'd3;
    localparam logic [2:0] FLD_HIPG = 3'd4;
    localparam logic [2:0] FLD_CURA = 3'd5;
    localparam logic [2:0] FLD_CURC = 3'd6;

endpackage

// File: rtl/dma_mm_chan.sv
module dma_mm_chan
    import dma_mm_pkg::*;
#(
    parameter int AW = 16,
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    field,
    input  logic [AW-1:0] wdata,
    input  logic          commit,
    output logic [AW-1:0] base_q,
    output logic [AW-1:0] cnt_q,
    output logic [AW-1:0] cur_a,
    output logic [AW-1:0] cur_c,
    output logic [1:0]    mode_q,
    output logic [PW-1:0] lo_pg,
    output logic [PW-1:0] hi_pg,
    output logic          done_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
            cur_a  <= '0;
            cur_c  <= '0;
            mode_q <= '0;
            lo_pg  <= '0;
            hi_pg  <= '0;
            done_q <= 1'b0;
        end else begin
            if (commit) begin
                cur_a <= cur_a + 1'b1;
                cur_c <= cur_c - 1'b1;
                if (cur_c == '0) done_q <= 1'b1;
            end
            if (wr_en) begin
                case (field)
                    FLD_BASE: begin
                        base_q <= wdata;
                        cur_a  <= wdata;
                    end
                    FLD_CNT: begin
                        cnt_q  <= wdata;
                        cur_c  <= wdata;
                        done_q <= 1'b0;
                    end
                    FLD_MODE: mode_q <= wdata[1:0];
                    FLD_LOPG: lo_pg  <= wdata[PW-1:0];
                    FLD_HIPG: hi_pg  <= wdata[PW-1:0];
                    default: ;
                endcase
            end
        end
    end

    // R6
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !wr_en) |=> cur_a == AW'($past(cur_a) + 1'b1));

    // R7
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !wr_en) |=> cur_c == AW'($past(cur_c) - 1'b1));

    // R8
    done_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !wr_en && cur_c == '0) |=> done_q);

endmodule

// File: rtl/dma_mm_rr.sv
module dma_mm_rr #(
    parameter int NCH = 7,
    parameter int CW  = 3
) (
    input  logic [NCH-1:0] elig,
    input  logic [CW-1:0]  start,
    output logic           any,
    output logic [CW-1:0]  win
);

    int idx;

    always_comb begin
        any = 1'b0;
        win = '0;
        idx = 0;
        for (int k = NCH - 1; k >= 0; k--) begin
            idx = (int'(start) + k) % NCH;
            if (elig[idx]) begin
                any = 1'b1;
                win = CW'(idx);
            end
        end
    end

endmodule

// File: rtl/dma_multimode_ctrl.sv
module dma_multimode_ctrl
    import dma_mm_pkg::*;
#(
    parameter int NCH        = 7,
    parameter int AW         = 16,
    parameter int PW         = 8,
    parameter int CYC_COMPAT = 8,
    parameter int CYC_A      = 6,
    parameter int CYC_B      = 4,
    parameter int CYC_C      = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    io_wr,
    input  logic [$clog2(NCH)+2:0]  io_addr,
    input  logic [AW-1:0]           io_wdata,
    output logic [AW-1:0]           io_rdata,
    input  logic [NCH-1:0]          dreq,
    output logic [NCH-1:0]          dack,
    output logic [AW+2*PW-1:0]      bus_addr,
    output logic                    bus_strobe,
    output logic                    bus_tc
);

    localparam int CW   = $clog2(NCH);
    localparam int TW   = AW + 2 * PW;
    localparam int MX1  = (CYC_COMPAT > CYC_A) ? CYC_COMPAT : CYC_A;
    localparam int MX2  = (CYC_B > CYC_C) ? CYC_B : CYC_C;
    localparam int MAXC = (MX1 > MX2) ? MX1 : MX2;
    localparam int YW   = $clog2(MAXC + 1);

    logic [CW-1:0] sel_ch;
    logic [2:0]    field;
    assign sel_ch = io_addr[CW+2:3];
    assign field  = io_addr[2:0];

    logic [AW-1:0] base_v [NCH];
    logic [AW-1:0] cnt_v  [NCH];
    logic [AW-1:0] cur_a_v[NCH];
    logic [AW-1:0] cur_c_v[NCH];
    logic [1:0]    mode_v [NCH];
    logic [PW-1:0] lo_v   [NCH];
    logic [PW-1:0] hi_v   [NCH];
    logic [NCH-1:0] done_v;

    state_e        state_q, state_d;
    logic [CW-1:0] cur_ch_q, ptr_q, win;
    logic [YW-1:0] cyc_q;
    logic          any, last, tc_now, load;
    logic [NCH-1:0] cur_1h, elig;

    assign cur_1h = {{(NCH-1){1'b0}}, 1'b1} << cur_ch_q;
    assign last   = (state_q == ST_XFER) && (cyc_q == '0);
    assign tc_now = last && (cur_c_v[cur_ch_q] == '0);
    assign elig   = dreq & ~done_v & (tc_now ? ~cur_1h : '1);
    assign load   = any && ((state_q == ST_IDLE) || last);

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_ch
            dma_mm_chan #(.AW(AW), .PW(PW)) chan_i (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_en  (io_wr && (sel_ch == CW'(g))),
                .field  (field),
                .wdata  (io_wdata),
                .commit (last && (cur_ch_q == CW'(g))),
                .base_q (base_v[g]),
                .cnt_q  (cnt_v[g]),
                .cur_a  (cur_a_v[g]),
                .cur_c  (cur_c_v[g]),
                .mode_q (mode_v[g]),
                .lo_pg  (lo_v[g]),
                .hi_pg  (hi_v[g]),
                .done_q (done_v[g])
            );
        end
    endgenerate

    dma_mm_rr #(.NCH(NCH), .CW(CW)) rr_i (
        .elig  (elig),
        .start (ptr_q),
        .any   (any),
        .win   (win)
    );

    function automatic logic [YW-1:0] cyc_len(input logic [1:0] m);
        unique case (tmode_e'(m))
            TM_COMPAT: cyc_len = YW'(CYC_COMPAT - 1);
            TM_A:      cyc_len = YW'(CYC_A - 1);
            TM_B:      cyc_len = YW'(CYC_B - 1);
            TM_C:      cyc_len = YW'(CYC_C - 1);
        endcase
    endfunction

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (any) state_d = ST_XFER;
            ST_XFER: if (last && !any) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cur_ch_q <= '0;
            cyc_q    <= '0;
            ptr_q    <= '0;
        end else begin
            state_q <= state_d;
            if (load) begin
                cur_ch_q <= win;
                cyc_q    <= cyc_len(mode_v[win]);
                ptr_q    <= (win == CW'(NCH - 1)) ? '0 : win + 1'b1;
            end else if (state_q == ST_XFER) begin
                cyc_q <= cyc_q - 1'b1;
            end
        end
    end

    always_comb begin
        bus_strobe = (state_q == ST_XFER);
        dack       = bus_strobe ? cur_1h : '0;
        bus_addr   = bus_strobe ? {hi_v[cur_ch_q], lo_v[cur_ch_q], cur_a_v[cur_ch_q]}
                                : TW'(0);
        bus_tc     = tc_now;
        io_rdata   = '0;
        if (int'(sel_ch) < NCH) begin
            case (field)
                FLD_BASE: io_rdata = base_v[sel_ch];
                FLD_CNT:  io_rdata = cnt_v[sel_ch];
                FLD_MODE: io_rdata = AW'(mode_v[sel_ch]);
                FLD_LOPG: io_rdata = AW'(lo_v[sel_ch]);
                FLD_HIPG: io_rdata = AW'(hi_v[sel_ch]);
                FLD_CURA: io_rdata = cur_a_v[sel_ch];
                FLD_CURC: io_rdata = cur_c_v[sel_ch];
                default:  io_rdata = '0;
            endcase
        end
    end

    // R5
    ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dack) && ((dack != '0) == bus_strobe));

    // R7
    tc_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_tc |-> bus_strobe);

    // R4
    strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_strobe && cyc_q != '0) |=> (bus_strobe && $stable(dack)));

    // R8
    done_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dack & done_v) == '0);

endmodule

// File: tb/dma_multimode_ctrl_tb_top.sv
module dma_multimode_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        io_wr;
    logic [5:0]  io_addr;
    logic [15:0] io_wdata;
    logic [15:0] io_rdata;
    logic [6:0]  dreq;
    logic [6:0]  dack;
    logic [31:0] bus_addr;
    logic        bus_strobe;
    logic        bus_tc;

    int n_chk = 0;
    int n_bad = 0;
    bit summary_done = 1'b0;

    always #4 clk = ~clk;

    dma_multimode_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .dreq(dreq), .dack(dack),
        .bus_addr(bus_addr), .bus_strobe(bus_strobe), .bus_tc(bus_tc)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; io_wr = 1'b0; io_addr = '0; io_wdata = '0; dreq = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input int ch, input int fld, input logic [15:0] d);
        io_wr = 1'b1; io_addr = {3'(ch), 3'(fld)}; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(input int ch, input int fld, output logic [15:0] d);
        io_addr = {3'(ch), 3'(fld)};
        #1 d = io_rdata;
    endtask

    task automatic prog(input int ch, input logic [15:0] base, input logic [15:0] cnt,
                        input int mode, input logic [7:0] lo, input logic [7:0] hi);
        wr(ch, 0, base); wr(ch, 1, cnt); wr(ch, 2, 16'(mode));
        wr(ch, 3, {8'h00, lo}); wr(ch, 4, {8'h00, hi});
    endtask

    task automatic t_reset();
        logic [15:0] d;
        do_reset();
        check(bus_strobe == 1'b0, "R1 strobe", 32'(bus_strobe), 0);
        check(dack == '0 && bus_tc == 1'b0, "R1 ack/tc", {dack, bus_tc}, 0);
        rd(2, 0, d);
        check(d == 16'h0, "R1 base reg", d, 0);
    endtask

    task automatic t_regs();
        logic [15:0] d;
        prog(3, 16'hBEEF, 16'h0102, 2, 8'h5A, 8'hC3);
        rd(3, 0, d); check(d == 16'hBEEF, "R2 base", d, 32'hBEEF);
        rd(3, 1, d); check(d == 16'h0102, "R2 count", d, 32'h0102);
        rd(3, 2, d); check(d == 16'h0002, "R2 mode", d, 2);
        rd(3, 3, d); check(d == 16'h005A, "R2 low page", d, 32'h5A);
        rd(3, 4, d); check(d == 16'h00C3, "R2 high page", d, 32'hC3);
        rd(3, 5, d); check(d == 16'hBEEF, "R2 running addr", d, 32'hBEEF);
        rd(3, 6, d); check(d == 16'h0102, "R2 running count", d, 32'h0102);
        wr(7, 0, 16'h1111);
        rd(7, 0, d); check(d == 16'h0, "R2 channel 7 reads zero", d, 0);
        rd(3, 0, d); check(d == 16'hBEEF, "R2 channel 7 write ignored", d, 32'hBEEF);
    endtask

    task automatic t_single(input int ch, input int mode, input int width,
                            input logic [15:0] base, input logic [7:0] lo,
                            input logic [7:0] hi);
        logic [15:0] d;
        int w = 0;
        int tci = -1;
        prog(ch, base, 16'h0000, mode, lo, hi);
        dreq[ch] = 1'b1;
        @(negedge clk);
        check(bus_strobe == 1'b1, "R10 start latency", 32'(bus_strobe), 1);
        check(bus_addr == {hi, lo, base}, "R3 address", bus_addr, {hi, lo, base});
        check(dack == 7'(1 << ch), "R5 ack", 32'(dack), 32'(1 << ch));
        while (bus_strobe && w < 20) begin
            w++;
            if (bus_tc) begin
                tci = w;
                dreq[ch] = 1'b0;
            end
            @(negedge clk);
        end
        dreq[ch] = 1'b0;
        check(w == width, "R4 strobe length", 32'(w), 32'(width));
        check(tci == width, "R7 tc in last cycle", 32'(tci), 32'(width));
        rd(ch, 5, d);
        check(d == base + 16'd1, "R6 address step", d, 32'(base + 16'd1));
        rd(ch, 6, d);
        check(d == 16'hFFFF, "R7 count wraps", d, 32'hFFFF);
    endtask

    task automatic t_burst();
        logic [15:0] base = 16'h1230;
        prog(4, base, 16'd3, 3, 8'hA5, 8'h3C);
        dreq[4] = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            check(bus_strobe == 1'b1, "R10 back-to-back", 32'(bus_strobe), 1);
            check(bus_addr == {8'h3C, 8'hA5, 16'(base + 16'(i))}, "R3 burst address",
                  bus_addr, {8'h3C, 8'hA5, 16'(base + 16'(i))});
            check(bus_tc == (i == 3), "R7 burst tc", 32'(bus_tc), 32'(i == 3));
            if (i == 3) dreq[4] = 1'b0;
            @(negedge clk);
        end
        check(bus_strobe == 1'b0, "R7 stop after K+1", 32'(bus_strobe), 0);
    endtask

    task automatic t_wrap();
        logic [15:0] d;
        prog(0, 16'hFFFF, 16'd1, 3, 8'h12, 8'h34);
        dreq[0] = 1'b1;
        @(negedge clk);
        check(bus_addr == 32'h3412FFFF, "R6 before wrap", bus_addr, 32'h3412FFFF);
        @(negedge clk);
        check(bus_addr == 32'h34120000, "R6 wrap keeps pages", bus_addr, 32'h34120000);
        dreq[0] = 1'b0;
        @(negedge clk);
        rd(0, 5, d);
        check(d == 16'h0001, "R6 running addr after wrap", d, 1);
    endtask

    task automatic t_done();
        int seen = 0;
        int k = 0;
        prog(6, 16'h0400, 16'd0, 2, 8'h00, 8'h00);
        dreq[6] = 1'b1;
        while (!bus_tc && k < 20) begin @(negedge clk); k++; end
        @(negedge clk);
        for (int i = 0; i < 12; i++) begin
            if (bus_strobe) seen++;
            @(negedge clk);
        end
        check(seen == 0, "R8 ignored after tc", 32'(seen), 0);
        wr(6, 1, 16'd0);
        seen = 0;
        for (int i = 0; i < 3; i++) begin
            if (bus_strobe) seen++;
            @(negedge clk);
        end
        check(seen != 0, "R8 re-armed by count write", 32'(seen), 1);
        k = 0;
        while (bus_strobe && k < 20) begin @(negedge clk); k++; end
        dreq[6] = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_rotate();
        int exp_seq[9] = '{1, 2, 5, 1, 2, 5, 1, 2, 5};
        do_reset();
        prog(1, 16'h0100, 16'd2, 3, 8'h00, 8'h00);
        prog(2, 16'h0200, 16'd2, 3, 8'h00, 8'h00);
        prog(5, 16'h0500, 16'd2, 3, 8'h00, 8'h00);
        dreq = 7'b0100110;
        @(negedge clk);
        for (int i = 0; i < 9; i++) begin
            check(dack == 7'(1 << exp_seq[i]), "R9 rotation order",
                  32'(dack), 32'(1 << exp_seq[i]));
            @(negedge clk);
        end
        dreq = '0;
        check(bus_strobe == 1'b0, "R9 all channels finished", 32'(bus_strobe), 0);
        prog(0, 16'h0000, 16'd0, 3, 8'h00, 8'h00);
        prog(6, 16'h0600, 16'd0, 3, 8'h00, 8'h00);
        dreq = 7'b1000001;
        @(negedge clk);
        check(dack == 7'b1000000, "R9 pointer after channel 5", 32'(dack), 32'h40);
        @(negedge clk);
        check(dack == 7'b0000001, "R9 wrap to channel 0", 32'(dack), 32'h01);
        dreq = '0;
        @(negedge clk);
    endtask

    task automatic summary();
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        end
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        t_reset();
        t_regs();
        t_single(3, 0, 8, 16'h2000, 8'h11, 8'h80);
        t_single(2, 1, 6, 16'h3000, 8'h22, 8'h81);
        t_single(1, 2, 4, 16'h4000, 8'h33, 8'h82);
        t_single(5, 3, 1, 16'h5000, 8'h44, 8'h83);
        t_burst();
        t_wrap();
        t_done();
        t_rotate();
        summary();
    end

endmodule